// File: doc/BRIEF.md
# Indexed Register Memory Transfer Unit

This block holds a small word-addressed memory together with two banks of three registers each: an address bank (program counter, memory address and I/O address slots) and a data bank (instruction, data and buffer slots). A 2-bit address index picks which address register drives the internal address bus. A 2-bit data index picks which data register is the source or the destination of a transfer. A read copies the addressed memory word into the chosen data register. A write stores the chosen data register into the addressed memory word.

Every register in both banks can be preloaded from a port through its own enable. The memory and both banks are cleared by reset. The address bus and the data bus are visible at the ports, and so is the content of every register. This lets a controller see every transfer as it happens.

Top module: `memxfer`

## Requirements
- R1: After reset every address register, every data register and every memory word is zero, and `err` is low.
- R2: When `aload_en[k]` is high at a rising edge, address register k (k = 0, 1 or 2) takes `aload_val`. It appears at `addr_q[k*AW +: AW]`.
- R3: When `dload_en[k]` is high at a rising edge, data register k takes `dload_val`. It appears at `data_q[k*DW +: DW]`. A port load wins over a read transfer into the same register at that edge.
- R4: A read happens at an edge where `rd` is high, `wr` is low and both `sel_a` and `sel_d` are below 3. Data register `sel_d` then takes the memory word at the address held in address register `sel_a`. The address used is the value from before any address load at that same edge.
- R5: A write happens at an edge where `wr` is high, `rd` is low and both indices are below 3. The memory word at address register `sel_a` then takes the value of data register `sel_d`. A later read shows the stored word.
- R6: If either index equals 3, the request is suppressed. No data register and no memory word changes, except through port loads.
- R7: If `rd` and `wr` are both high at an edge, no transfer happens and `err` is high for the following cycle. In every other case `err` is low.
- R8: `abus` shows address register `sel_a` combinationally. It is zero when `sel_a` is 3.
- R9: `dbus` shows data register `sel_d` during a valid write and the addressed memory word during a valid read. It is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| aload_en | input | 3 | Per-register load enables for the address bank |
| aload_val | input | AW | Value loaded into the address registers |
| dload_en | input | 3 | Per-register load enables for the data bank |
| dload_val | input | DW | Value loaded into the data registers |
| rd | input | 1 | Read request: data register gets memory word |
| wr | input | 1 | Write request: memory word gets data register |
| sel_a | input | 2 | Address register index (3 = none) |
| sel_d | input | 2 | Data register index (3 = none) |
| abus | output | AW | Address bus |
| dbus | output | DW | Data bus |
| addr_q | output | 3*AW | Address registers, slot k at bits k*AW and up |
| data_q | output | 3*DW | Data registers, slot k at bits k*DW and up |
| err | output | 1 | Read and write requested together at the previous edge |

## Verification
The two buses are combinational, so the bench checks them in the same cycle the inputs are applied, one time step after it drives them. Register loads, transfers, memory writes and `err` all take effect at the next rising edge, so they are checked at the following falling edge, before new inputs are driven. A memory write is confirmed one edge later by a read that brings the stored word back through a data register. The bench keeps its own copy of both banks and the memory. It advances that copy at each edge from the requirements alone.

// File: rtl/memxfer.sv
module memxfer #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      aload_en,
  input  logic [AW-1:0]   aload_val,
  input  logic [2:0]      dload_en,
  input  logic [DW-1:0]   dload_val,
  input  logic            rd,
  input  logic            wr,
  input  logic [1:0]      sel_a,
  input  logic [1:0]      sel_d,
  output logic [AW-1:0]   abus,
  output logic [DW-1:0]   dbus,
  output logic [3*AW-1:0] addr_q,
  output logic [3*DW-1:0] data_q,
  output logic            err
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] areg [3];
  logic [DW-1:0] dreg [3];
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] d_sel;

  wire a_ok  = sel_a != 2'd3;
  wire d_ok  = sel_d != 2'd3;
  wire do_rd = rd && !wr && a_ok && d_ok;
  wire do_wr = wr && !rd && a_ok && d_ok;

  always_comb begin
    case (sel_a)
      2'd0:    abus = areg[0];
      2'd1:    abus = areg[1];
      2'd2:    abus = areg[2];
      default: abus = '0;
    endcase
  end

  always_comb begin
    case (sel_d)
      2'd0:    d_sel = dreg[0];
      2'd1:    d_sel = dreg[1];
      2'd2:    d_sel = dreg[2];
      default: d_sel = '0;
    endcase
  end

  assign dbus = do_wr ? d_sel : (do_rd ? mem[abus] : '0);

  for (genvar k = 0; k < 3; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) areg[k] <= '0;
      else if (aload_en[k]) areg[k] <= aload_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dreg[k] <= '0;
      else if (dload_en[k]) dreg[k] <= dload_val;
      else if (do_rd && sel_d == 2'(k)) dreg[k] <= mem[abus];
    end

    assign addr_q[k*AW +: AW] = areg[k];
    assign data_q[k*DW +: DW] = dreg[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_wr) begin
      mem[abus] <= d_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else err <= rd && wr;
  end

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aload_en[1] |=> addr_q[AW +: AW] == $past(aload_val));

  // R4
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && dload_en == 3'b000) |=> dreg[$past(sel_d)] == $past(dbus));

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> mem[$past(abus)] == $past(d_sel));

  // R6
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && (!a_ok || !d_ok) && dload_en == 3'b000) |=> $stable(data_q));

  // R7
  conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr && dload_en == 3'b000) |=> ($stable(data_q) && err));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |-> dbus == '0);
endmodule

// File: tb/sim_memxfer.sv
module sim_memxfer;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] aload_en = '0, dload_en = '0;
  logic [AW-1:0] aload_val = '0;
  logic [DW-1:0] dload_val = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [1:0] sel_a = '0, sel_d = '0;
  logic [AW-1:0] abus;
  logic [DW-1:0] dbus;
  logic [3*AW-1:0] addr_q;
  logic [3*DW-1:0] data_q;
  logic err;

  int checks = 0, errors = 0;
  logic [AW-1:0] ma [3];
  logic [DW-1:0] md [3];
  logic [DW-1:0] mm [DEPTH];
  logic exp_err = 1'b0;

  always #10 clk = ~clk;

  memxfer #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .aload_en(aload_en), .aload_val(aload_val),
    .dload_en(dload_en), .dload_val(dload_val), .rd(rd), .wr(wr),
    .sel_a(sel_a), .sel_d(sel_d), .abus(abus), .dbus(dbus),
    .addr_q(addr_q), .data_q(data_q), .err(err));

  function automatic logic [AW-1:0] exp_abus();
    return (sel_a == 2'd3) ? '0 : ma[sel_a];
  endfunction

  function automatic logic [DW-1:0] exp_dbus();
    if (sel_a == 2'd3 || sel_d == 2'd3 || rd == wr) return '0;
    return wr ? md[sel_d] : mm[ma[sel_a]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    for (int k = 0; k < 3; k++) begin
      chk(req, 32'(addr_q[k*AW +: AW]), 32'(ma[k]));
      chk(req, 32'(data_q[k*DW +: DW]), 32'(md[k]));
    end
    chk("R7", 32'(err), 32'(exp_err));
  endtask

  task automatic cycle(input string req);
    logic [AW-1:0] a_old [3];
    logic [DW-1:0] d_old [3];
    logic vrd, vwr;
    #1;
    chk("R8", 32'(abus), 32'(exp_abus()));
    chk("R9", 32'(dbus), 32'(exp_dbus()));
    a_old = ma; d_old = md;
    vrd = rd && !wr && sel_a != 2'd3 && sel_d != 2'd3;
    vwr = wr && !rd && sel_a != 2'd3 && sel_d != 2'd3;
    @(posedge clk);
    if (vwr) mm[a_old[sel_a]] = d_old[sel_d];
    if (vrd) md[sel_d] = mm[a_old[sel_a]];
    for (int k = 0; k < 3; k++) begin
      if (aload_en[k]) ma[k] = aload_val;
      if (dload_en[k]) md[k] = dload_val;
    end
    exp_err = rd && wr;
    @(negedge clk);
    check_state(req);
    aload_en = '0; dload_en = '0; rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 3; k++) begin ma[k] = '0; md[k] = '0; end
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // R2/R3 directed loads
    aload_en = 3'b001; aload_val = 4'd5; dload_en = 3'b100; dload_val = 8'hA7;
    cycle("R2");
    aload_en = 3'b010; aload_val = 4'd9; dload_en = 3'b001; dload_val = 8'h3C;
    cycle("R3");
    // R5 write buf slot to M[5], then R4 read back into data slot 1
    wr = 1'b1; sel_a = 2'd0; sel_d = 2'd2; cycle("R5");
    rd = 1'b1; sel_a = 2'd0; sel_d = 2'd1; cycle("R4");
    chk("R5", 32'(data_q[DW +: DW]), 32'h0A7);
    // R4 address from before same-edge load
    rd = 1'b1; sel_a = 2'd0; sel_d = 2'd0; aload_en = 3'b001; aload_val = 4'd1;
    cycle("R4");
    // R3 port load beats read
    rd = 1'b1; sel_a = 2'd1; sel_d = 2'd1; dload_en = 3'b010; dload_val = 8'h55;
    cycle("R3");
    // R6 index 3
    wr = 1'b1; sel_a = 2'd3; sel_d = 2'd0; cycle("R6");
    rd = 1'b1; sel_a = 2'd0; sel_d = 2'd3; cycle("R6");
    // R7 conflict, then err drops
    rd = 1'b1; wr = 1'b1; sel_a = 2'd0; sel_d = 2'd2; cycle("R7");
    cycle("R7");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      rd = r < 4 || r == 9;
      wr = (r >= 4 && r < 8) || r == 9;
      sel_a = 2'($urandom_range(0, 3));
      sel_d = 2'($urandom_range(0, 3));
      aload_en = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
      dload_en = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
      aload_val = AW'($urandom);
      dload_val = DW'($urandom);
      cycle("R4/R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule